// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Controller

This block sequences the feedback divider of a fractional-N frequency synthesizer. An external multi-modulus prescaler divides the oscillator by P or P+1. It reports the end of each of its own cycles as a single-clock pulse on `pre_pulse`. The block answers on `mod_sel`, which picks P+1 when high and P when low. It raises `div_out` once per completed divider cycle.

Each divider cycle spans B prescaler cycles. The first S of them run at P+1 and the rest at P, so the cycle divides by P·B+S. In integer mode S is the programmed swallow value A. In fractional mode a second-order noise-shaping modulator adds a dither of −2…+2 to A at the start of every cycle. The modulator is built from two cascaded accumulators that wrap at 62976. The long-run ratio is therefore P·B+A+F/62976, where F is a signed 17-bit fraction word. A counter-reset input holds the whole sequencer, modulator included, at its starting point.

Top module: `fracn_swallow_div`

## Requirements
- R1: While `rst` or `cnt_rst` is high, `mod_sel` and `div_out` are low and prescaler pulses are not counted. In the first clock after release the block loads a fresh cycle and ignores any pulse in that clock; from the next clock on it counts from the start of a cycle.
- R2: In integer mode (`frac_en` low) every cycle covers B prescaler pulses. `mod_sel` is high during the first A of them and low during the remaining B−A, so a cycle spans P·B+A oscillator periods. `mod_sel` changes only at a prescaler pulse, at a cycle load or under a hold.
- R3: `div_out` is a one-clock pulse in the clock that follows the prescaler pulse completing a cycle.
- R4: With P=8 only the low three bits of the 4-bit `a_val` count. For example `a_val`=9 acts as A=1. With P=16 all four bits count.
- R5: With `frac_en` high from reset, the total over the first k cycles is exactly k·(P·B+A)+k·F/62976 whenever k·F is a multiple of 62976. In particular it holds for k=62976 and any F in −31488…+31488, with F in two's complement.
- R6: In fractional mode each cycle's ratio lies within P·B+A−2 … P·B+A+2 whenever that range fits inside P·B … P·B+B.
- R7: The swallow count loaded for a cycle is A plus the dither, limited to 0…B. A cycle therefore never divides by less than P·B or more than P·B+B; for example A=7 with B=3 gives P·B+3.
- R8: With `frac_en` low the modulator is cleared and F has no effect: every cycle divides by exactly P·B+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_pulse | input | 1 | One-clock pulse at the end of each prescaler cycle |
| b_val | input | 7 | Main count B (3…127) |
| a_val | input | 4 | Swallow count A (below B) |
| f_val | input | 17 | Signed fraction word F |
| frac_en | input | 1 | High selects fractional mode |
| cnt_rst | input | 1 | Holds counters and modulator at their start while high |
| mod_sel | output | 1 | High requests modulus P+1, low requests P |
| div_out | output | 1 | One pulse per completed divider cycle |

## Verification
The hardest condition to reach is the point where the modulator's two accumulators both close their period, since exactness of the long-run ratio shows only there. The bench pulses the prescaler input on every clock and uses B=3, so the full 62976-cycle window fits in the run. Short windows where k·F is a whole multiple of the modulus give exact checks quickly. Examples are 164 cycles for F=3456 and 4 cycles for F=−31488. Clamping is driven with F=−31488 and A=0, which asks for negative swallow counts, and with A above B.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int PRE_MOD_DEF  = 8;
    localparam int B_W_DEF      = 7;
    localparam int A_W_DEF      = 4;
    localparam int F_W_DEF      = 17;
    localparam int FRAC_MOD_DEF = 62976;

    typedef enum logic [1:0] {
        PH_EMPTY   = 2'd0,
        PH_SWALLOW = 2'd1,
        PH_MAIN    = 2'd2
    } cyc_phase_e;

    typedef logic signed [2:0] dither_t;

    function automatic int sat_swallow(input int a, input int d, input int b);
        int t;
        t = a + d;
        if (t < 0) return 0;
        if (t > b) return b;
        return t;
    endfunction

endpackage

// File: rtl/fsd_mash2.sv
module fsd_mash2 #(
    parameter int F_W = fsd_pkg::F_W_DEF,
    parameter int MOD = fsd_pkg::FRAC_MOD_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step,
    input  logic [F_W-1:0]       frac_word,
    output fsd_pkg::dither_t     dither
);
    localparam int ACC_W  = $clog2(MOD);
    localparam int STAGES = 2;
    localparam logic [ACC_W:0] MOD_V = (ACC_W+1)'(MOD);

    logic                 neg;
    logic signed [F_W:0]  f_ext;
    logic signed [F_W:0]  f_wrap;
    logic [ACC_W-1:0]     incr;
    logic                 unused_wrap_top;

    assign neg    = frac_word[F_W-1];
    assign f_ext  = {frac_word[F_W-1], frac_word};
    // negative words are folded into 0..MOD-1; the lost unit is subtracted below
    assign f_wrap = neg ? (f_ext + (F_W+1)'(MOD)) : f_ext;
    assign incr   = f_wrap[ACC_W-1:0];
    assign unused_wrap_top = ^f_wrap[F_W:ACC_W];

    logic [ACC_W-1:0] acc_nx [STAGES];
    logic [STAGES-1:0] cy;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [ACC_W-1:0] acc_r;
        logic [ACC_W-1:0] stg_in;
        logic [ACC_W:0]   sum;

        if (g == 0) begin : g_head
            assign stg_in = incr;
        end else begin : g_tail
            assign stg_in = acc_nx[g-1];
        end

        assign sum       = {1'b0, acc_r} + {1'b0, stg_in};
        assign cy[g]     = (sum >= MOD_V);
        assign acc_nx[g] = cy[g] ? ACC_W'(sum - MOD_V) : sum[ACC_W-1:0];

        always_ff @(posedge clk) begin
            if (rst || clr)  acc_r <= '0;
            else if (step)   acc_r <= acc_nx[g];
        end
    end

    logic c2_d;
    always_ff @(posedge clk) begin
        if (rst || clr)  c2_d <= 1'b0;
        else if (step)   c2_d <= cy[1];
    end

    assign dither = $signed({2'b00, cy[0]}) + $signed({2'b00, cy[1]})
                  - $signed({2'b00, c2_d})  - $signed({2'b00, neg});

endmodule

// File: rtl/fsd_cycle_ctr.sv
module fsd_cycle_ctr #(
    parameter int B_W = fsd_pkg::B_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic           pre_pulse,
    input  logic [B_W-1:0] b_val,
    input  logic [B_W-1:0] s_val,
    output logic           load_go,
    output logic           term,
    output logic           mod_sel
);
    import fsd_pkg::*;

    cyc_phase_e     ph_q;
    logic [B_W-1:0] main_q;
    logic [B_W-1:0] swl_q;
    logic           last;

    assign last    = (main_q == B_W'(1));
    assign term    = pre_pulse && last;
    assign load_go = (ph_q == PH_EMPTY) || term;
    assign mod_sel = (ph_q == PH_SWALLOW);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph_q   <= PH_EMPTY;
            main_q <= '0;
            swl_q  <= '0;
        end else if (load_go) begin
            main_q <= b_val;
            swl_q  <= s_val;
            ph_q   <= (s_val != '0) ? PH_SWALLOW : PH_MAIN;
        end else if (pre_pulse) begin
            main_q <= main_q - B_W'(1);
            if (ph_q == PH_SWALLOW) begin
                swl_q <= swl_q - B_W'(1);
                if (swl_q == B_W'(1)) ph_q <= PH_MAIN;
            end
        end
    end

endmodule

// File: rtl/fracn_swallow_div.sv
module fracn_swallow_div #(
    parameter int PRE_MOD  = fsd_pkg::PRE_MOD_DEF,
    parameter int B_W      = fsd_pkg::B_W_DEF,
    parameter int A_W      = fsd_pkg::A_W_DEF,
    parameter int F_W      = fsd_pkg::F_W_DEF,
    parameter int FRAC_MOD = fsd_pkg::FRAC_MOD_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_pulse,
    input  logic [B_W-1:0] b_val,
    input  logic [A_W-1:0] a_val,
    input  logic [F_W-1:0] f_val,
    input  logic           frac_en,
    input  logic           cnt_rst,
    output logic           mod_sel,
    output logic           div_out
);
    import fsd_pkg::*;

    localparam int A_USED = $clog2(PRE_MOD);

    logic [A_W-1:0] a_eff;

    if (A_USED < A_W) begin : g_trim
        logic unused_a_hi;
        assign unused_a_hi = ^a_val[A_W-1:A_USED];
        assign a_eff = {{(A_W-A_USED){1'b0}}, a_val[A_USED-1:0]};
    end else begin : g_full
        assign a_eff = a_val;
    end

    dither_t        dith_raw;
    dither_t        dith_use;
    logic [B_W-1:0] swl_load;
    logic           load_go;
    logic           term;

    assign dith_use = frac_en ? dith_raw : dither_t'(0);
    assign swl_load = B_W'(sat_swallow(int'(a_eff), int'(dith_use), int'(b_val)));

    fsd_mash2 #(.F_W(F_W), .MOD(FRAC_MOD)) u_mod (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_rst || !frac_en),
        .step      (load_go && frac_en),
        .frac_word (f_val),
        .dither    (dith_raw)
    );

    fsd_cycle_ctr #(.B_W(B_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .hold      (cnt_rst),
        .pre_pulse (pre_pulse),
        .b_val     (b_val),
        .s_val     (swl_load),
        .load_go   (load_go),
        .term      (term),
        .mod_sel   (mod_sel)
    );

    always_ff @(posedge clk) begin
        if (rst || cnt_rst) div_out <= 1'b0;
        else                div_out <= term;
    end

endmodule

// File: rtl/fsd_chk.sv
module fsd_chk (
    input logic clk,
    input logic rst,
    input logic cnt_rst,
    input logic pre_pulse,
    input logic mod_sel,
    input logic div_out
);
    logic fresh_q;
    always_ff @(posedge clk) fresh_q <= rst || cnt_rst;

    a_r3_after_pulse: assert property (@(posedge clk) disable iff (rst)
        div_out |-> $past(pre_pulse));

    a_r3_one_clock: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    a_r1_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> (!div_out && !mod_sel));

    a_r2_sel_falls_on_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel) |-> $past(pre_pulse || cnt_rst));

    a_r2_sel_rises_on_load: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_sel) |-> (div_out || $past(fresh_q)));

endmodule

bind fracn_swallow_div fsd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_rst   (cnt_rst),
    .pre_pulse (pre_pulse),
    .mod_sel   (mod_sel),
    .div_out   (div_out)
);

// File: tb/fracn_swallow_div_bench.sv
module fracn_swallow_div_bench;
    localparam int P    = 8;
    localparam int M    = 62976;
    localparam int WD   = 198000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_pulse = 1'b0;
    logic [6:0]  b_val = 7'd12;
    logic [3:0]  a_val = 4'd1;
    logic [16:0] f_val = '0;
    logic        frac_en = 1'b0;
    logic        cnt_rst = 1'b0;
    logic        mod_sel;
    logic        div_out;

    int n_chk = 0;
    int n_err = 0;
    int clk_cnt = 0;

    always #5 clk = ~clk;

    fracn_swallow_div u_fracn_swallow_div (
        .clk(clk), .rst(rst), .pre_pulse(pre_pulse), .b_val(b_val), .a_val(a_val),
        .f_val(f_val), .frac_en(frac_en), .cnt_rst(cnt_rst),
        .mod_sel(mod_sel), .div_out(div_out)
    );

    always @(posedge clk) begin
        clk_cnt++;
        if (clk_cnt == WD) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d clocks expected below %0d", clk_cnt, WD);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input int b, input int a, input int f, input bit fe);
        b_val = 7'(b); a_val = 4'(a); f_val = 17'(f); frac_en = fe;
        pre_pulse = 1'b0; cnt_rst = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure(input int ncyc, output longint total, output int rmin,
                           output int rmax, output int bad_pc, output int bad_order,
                           output int bad_width);
        int cur = 0; int pc = 0; int cyc = 0;
        bit seen_low = 1'b0; bit prev_do = 1'b0;
        total = 0; rmin = 1 << 30; rmax = 0; bad_pc = 0; bad_order = 0; bad_width = 0;
        while (1) begin
            if (div_out) begin
                total += cur;
                if (cur < rmin) rmin = cur;
                if (cur > rmax) rmax = cur;
                if (pc != int'(b_val)) bad_pc++;
                if (prev_do) bad_width++;
                cyc++; cur = 0; pc = 0; seen_low = 1'b0;
            end
            prev_do = div_out;
            if (cyc == ncyc) break;
            if (mod_sel) begin
                if (seen_low) bad_order++;
                cur += P + 1;
            end else begin
                seen_low = 1'b1;
                cur += P;
            end
            pc++;
            pre_pulse = 1'b1;
            @(negedge clk);
        end
        pre_pulse = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(mod_sel == 1'b0, "R1", "mod_sel in reset", mod_sel, 0);
        chk(div_out == 1'b0, "R1", "div_out in reset", div_out, 0);
    endtask

    task automatic t_integer();
        longint t; int mn, mx, bp, bo, bw;
        setup(12, 1, 0, 1'b0);
        measure(3, t, mn, mx, bp, bo, bw);
        chk(mn == 97 && mx == 97, "R2", "integer ratio B=12 A=1", mn, 97);
        chk(bo == 0, "R2", "P+1 cycles lead the cycle", bo, 0);
        chk(bp == 0, "R3", "pulses per divider cycle", bp, 0);
        chk(bw == 0, "R3", "div_out width", bw, 0);
        setup(5, 0, 0, 1'b0);
        measure(2, t, mn, mx, bp, bo, bw);
        chk(mn == 40 && mx == 40, "R2", "integer ratio A=0", mx, 40);
    endtask

    task automatic t_mask();
        longint t; int mn, mx, bp, bo, bw;
        setup(5, 9, 0, 1'b0);
        measure(2, t, mn, mx, bp, bo, bw);
        chk(mn == 41 && mx == 41, "R4", "a_val=9 acts as A=1", mx, 41);
    endtask

    task automatic t_upper_clamp();
        longint t; int mn, mx, bp, bo, bw;
        setup(3, 7, 0, 1'b0);
        measure(2, t, mn, mx, bp, bo, bw);
        chk(mn == 27 && mx == 27, "R7", "swallow limited to B", mx, 27);
    endtask

    task automatic t_frac_off();
        longint t; int mn, mx, bp, bo, bw;
        setup(10, 3, 31488, 1'b0);
        measure(3, t, mn, mx, bp, bo, bw);
        chk(mn == 83 && mx == 83, "R8", "F ignored in integer mode", mn, 83);
    endtask

    task automatic t_cnt_rst();
        longint t; int mn, mx, bp, bo, bw;
        setup(12, 4, 0, 1'b0);
        pre_pulse = 1'b1;
        repeat (2) @(negedge clk);
        chk(mod_sel == 1'b1, "R2", "mod_sel high inside swallow phase", mod_sel, 1);
        pre_pulse = 1'b0; cnt_rst = 1'b1;
        @(negedge clk);
        chk(mod_sel == 1'b0 && div_out == 1'b0, "R1", "outputs under hold", mod_sel, 0);
        pre_pulse = 1'b1;
        repeat (15) @(negedge clk);
        chk(div_out == 1'b0, "R1", "pulses ignored under hold", div_out, 0);
        pre_pulse = 1'b0; cnt_rst = 1'b0;
        @(negedge clk);
        measure(2, t, mn, mx, bp, bo, bw);
        chk(mn == 100 && mx == 100, "R1", "fresh cycle after hold", mn, 100);
    endtask

    task automatic t_frac_example();
        longint t; int mn, mx, bp, bo, bw;
        setup(12, 1, 3456, 1'b1);
        measure(164, t, mn, mx, bp, bo, bw);
        chk(t == 164 * 97 + 9, "R5", "164-cycle total F=3456", t, 164 * 97 + 9);
        chk(mn >= 95 && mx <= 99, "R6", "per-cycle spread F=3456 (max)", mx, 99);
        chk(bo == 0, "R2", "swallow first in fractional mode", bo, 0);
    endtask

    task automatic t_frac_neg();
        longint t; int mn, mx, bp, bo, bw;
        setup(6, 3, -31488, 1'b1);
        measure(4, t, mn, mx, bp, bo, bw);
        chk(t == 202, "R5", "4-cycle total F=-31488", t, 202);
        chk(mn >= 49 && mx <= 53, "R6", "per-cycle spread F=-31488 (min)", mn, 49);
    endtask

    task automatic t_low_clamp();
        longint t; int mn, mx, bp, bo, bw;
        setup(3, 0, -31488, 1'b1);
        measure(4, t, mn, mx, bp, bo, bw);
        chk(mn == 24 && mx == 24, "R7", "swallow floored at zero", mn, 24);
    endtask

    task automatic t_full_period();
        longint t; int mn, mx, bp, bo, bw;
        longint exp_t;
        setup(3, 1, 3456, 1'b1);
        measure(M, t, mn, mx, bp, bo, bw);
        exp_t = longint'(M) * 25 + 3456;
        chk(t == exp_t, "R5", "full-period total", t, exp_t);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_mask();
        t_upper_clamp();
        t_frac_off();
        t_cnt_rst();
        t_frac_example();
        t_frac_neg();
        t_low_clamp();
        t_full_period();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule